// File: doc/BRIEF.md
# Coprocessor Instruction Disposition Resolver

This block sits in the decode stage of a microcontroller-class core. For every instruction that falls in coprocessor encoding space it settles the instruction's fate. It can hand the instruction on to the regular floating-point decoder, or make it undefined. It can turn it into a no-operation, or raise a no-coprocessor fault aimed at a given exception level. The last outcome is to run it as the secure lazy FP-context save or restore.

The decode stage drives the instruction fields and the core's feature flags, then pulses `req_valid`. One cycle later the registered disposition appears on the outputs. It stays there until the next pulse. The memory side of the lazy save or restore and the normal FP decoder are handled elsewhere. This block only reports which of them applies, and for a lazy operation it tells the front end to close the current instruction block.

Top module: `cpd_resolver`

## Requirements
- R1: Coprocessor number 11 is handled exactly as coprocessor 10, whether or not the v8.1 extension is present.
- R2: With `feat_v81` high, coprocessor numbers 8, 9, 14 and 15 are handled as coprocessor 10. With `feat_v81` low, they raise a no-coprocessor fault at `def_lvl`.
- R3: Any other number that is not 10 after remapping gives the no-coprocessor fault (`rsp_outcome` bit 3) with `rsp_fault_lvl` equal to `def_lvl`.
- R4: After remapping to 10, a non-zero `fp_trap_lvl` gives the no-coprocessor fault with `rsp_fault_lvl` equal to `fp_trap_lvl`. A zero trap level gives pass-through (`rsp_outcome` bit 0).
- R5: A lazy FP save or restore (`req_lazy` high) is recognised only when `feat_v8` is high. When `req_variant` is 1 it also needs `feat_v81`. If it is not recognised, it is resolved by the coprocessor rules R1 to R4 using `req_cp`.
- R6: A recognised lazy operation with `req_variant` 0 is undefined (`rsp_outcome` bit 1) when `feat_d32` is high.
- R7: A recognised lazy operation is undefined when `in_secure` is low, even if `fp_trap_lvl` is non-zero.
- R8: A recognised lazy operation in secure state with `feat_fpu` low is a no-operation (`rsp_outcome` bit 2), whatever the trap level.
- R9: A recognised lazy operation in secure state with an FPU executes (`rsp_outcome` bit 4) whatever the trap level. `rsp_lazy_load` equals `req_load` and `rsp_end_block` is high. Both are low for every other outcome.
- R10: Exactly one bit of `rsp_outcome` is set after any strobe. `rsp_fault_lvl` is zero unless bit 3 is set.
- R11: Results appear on the clock edge that samples `req_valid` high. `rsp_valid` is high for exactly that one cycle. The outputs hold until the next strobe, and reset clears all of them to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Strobe: sample the request fields this cycle |
| req_cp | input | 4 | Coprocessor number from the instruction |
| req_lazy | input | 1 | Instruction is the lazy FP save/restore form |
| req_variant | input | 1 | Encoding variant: 0 short register list, 1 long register list |
| req_load | input | 1 | Direction of the lazy operation: 1 restore, 0 save |
| feat_v8 | input | 1 | Core implements the v8 baseline |
| feat_v81 | input | 1 | Core implements the v8.1 extension |
| feat_fpu | input | 1 | FPU present |
| feat_d32 | input | 1 | 32 double-precision registers present |
| in_secure | input | 1 | Core is in secure state |
| fp_trap_lvl | input | 2 | Level to which FP access traps, 0 for none |
| def_lvl | input | 2 | Default exception level for coprocessor faults |
| rsp_valid | output | 1 | One-cycle pulse marking a fresh result |
| rsp_outcome | output | 5 | One-hot: 0 pass, 1 undefined, 2 no-op, 3 no-coprocessor fault, 4 lazy execute |
| rsp_fault_lvl | output | 2 | Target level of the fault, zero otherwise |
| rsp_lazy_load | output | 1 | Lazy operation is a restore |
| rsp_end_block | output | 1 | Front end must end the current instruction block |

## Verification
The bench targets the priority corners. One is a non-secure lazy operation while FP access traps: a design that let the fault win would report bit 3 instead of undefined. Another is the second encoding variant on a core without v8.1: a design that missed the fall-through would execute or undefine it rather than apply the coprocessor rules. The bench also sweeps every coprocessor number with and without v8.1 to catch a wrong alias set. It also runs idle cycles between strobes, where a design that updated every cycle would lose its held result.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

  localparam int NUM_DISP = 5;

  typedef enum logic [2:0] {
    DISP_PASS  = 3'd0,
    DISP_UNDEF = 3'd1,
    DISP_NOP   = 3'd2,
    DISP_NOCP  = 3'd3,
    DISP_LAZY  = 3'd4
  } disp_e;

  function automatic logic [NUM_DISP-1:0] disp_onehot(disp_e d);
    logic [NUM_DISP-1:0] v;
    v = '0;
    v[d] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/cpd_cp_fold.sv
module cpd_cp_fold #(
  parameter int          CP_W     = 4,
  parameter int          FP_CP    = 10,
  parameter int          ALIAS_CP = 11,
  parameter logic [15:0] EXT_MASK = 16'b1100_0011_0000_0000
) (
  input  logic [CP_W-1:0] cp,
  input  logic            ext_en,
  output logic [CP_W-1:0] cp_eff,
  output logic            is_fp_cp
);
  localparam int NCP = 1 << CP_W;

  logic [NCP-1:0] ext_hit;

  for (genvar i = 0; i < NCP; i++) begin : g_alias
    if (i < 16 && EXT_MASK[i % 16]) begin : g_on
      assign ext_hit[i] = (cp == CP_W'(i));
    end else begin : g_off
      assign ext_hit[i] = 1'b0;
    end
  end

  always_comb begin
    cp_eff = cp;
    if (cp == CP_W'(ALIAS_CP)) begin
      cp_eff = CP_W'(FP_CP);
    end else if (ext_en && |ext_hit) begin
      cp_eff = CP_W'(FP_CP);
    end
  end

  assign is_fp_cp = (cp_eff == CP_W'(FP_CP));
endmodule

// File: rtl/cpd_lazy_rule.sv
module cpd_lazy_rule
  import cpd_pkg::*;
(
  input  logic  lazy,
  input  logic  variant,
  input  logic  v8,
  input  logic  v81,
  input  logic  d32,
  input  logic  secure,
  input  logic  fpu,
  output logic  hit,
  output disp_e disp
);
  logic variant_ok;
  assign variant_ok = !variant || v81;
  assign hit        = lazy && v8 && variant_ok;

  always_comb begin
    if (!variant && d32)  disp = DISP_UNDEF;
    else if (!secure)     disp = DISP_UNDEF;
    else if (!fpu)        disp = DISP_NOP;
    else                  disp = DISP_LAZY;
  end
endmodule

// File: rtl/cpd_nocp_rule.sv
module cpd_nocp_rule
  import cpd_pkg::*;
#(
  parameter int LVL_W = 2
) (
  input  logic             is_fp_cp,
  input  logic [LVL_W-1:0] trap_lvl,
  input  logic [LVL_W-1:0] def_lvl,
  output disp_e            disp,
  output logic [LVL_W-1:0] lvl
);
  always_comb begin
    if (!is_fp_cp) begin
      disp = DISP_NOCP;
      lvl  = def_lvl;
    end else if (trap_lvl != '0) begin
      disp = DISP_NOCP;
      lvl  = trap_lvl;
    end else begin
      disp = DISP_PASS;
      lvl  = '0;
    end
  end
endmodule

// File: rtl/cpd_resolver.sv
module cpd_resolver
  import cpd_pkg::*;
#(
  parameter int CP_W  = 4,
  parameter int LVL_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [CP_W-1:0]     req_cp,
  input  logic                req_lazy,
  input  logic                req_variant,
  input  logic                req_load,
  input  logic                feat_v8,
  input  logic                feat_v81,
  input  logic                feat_fpu,
  input  logic                feat_d32,
  input  logic                in_secure,
  input  logic [LVL_W-1:0]    fp_trap_lvl,
  input  logic [LVL_W-1:0]    def_lvl,
  output logic                rsp_valid,
  output logic [NUM_DISP-1:0] rsp_outcome,
  output logic [LVL_W-1:0]    rsp_fault_lvl,
  output logic                rsp_lazy_load,
  output logic                rsp_end_block
);
  logic [CP_W-1:0]  cp_eff;
  logic             is_fp_cp;
  logic             lazy_hit;
  disp_e            lazy_disp;
  disp_e            nocp_disp;
  logic [LVL_W-1:0] nocp_lvl;
  disp_e            dec_disp;
  logic [LVL_W-1:0] dec_lvl;

  cpd_cp_fold #(.CP_W(CP_W)) u_fold (
    .cp       (req_cp),
    .ext_en   (feat_v81),
    .cp_eff   (cp_eff),
    .is_fp_cp (is_fp_cp)
  );

  cpd_lazy_rule u_lazy (
    .lazy    (req_lazy),
    .variant (req_variant),
    .v8      (feat_v8),
    .v81     (feat_v81),
    .d32     (feat_d32),
    .secure  (in_secure),
    .fpu     (feat_fpu),
    .hit     (lazy_hit),
    .disp    (lazy_disp)
  );

  cpd_nocp_rule #(.LVL_W(LVL_W)) u_nocp (
    .is_fp_cp (is_fp_cp),
    .trap_lvl (fp_trap_lvl),
    .def_lvl  (def_lvl),
    .disp     (nocp_disp),
    .lvl      (nocp_lvl)
  );

  assign dec_disp = lazy_hit ? lazy_disp : nocp_disp;
  assign dec_lvl  = (dec_disp == DISP_NOCP) ? nocp_lvl : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_outcome   <= '0;
      rsp_fault_lvl <= '0;
      rsp_lazy_load <= 1'b0;
      rsp_end_block <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_outcome   <= disp_onehot(dec_disp);
        rsp_fault_lvl <= dec_lvl;
        rsp_lazy_load <= (dec_disp == DISP_LAZY) && req_load;
        rsp_end_block <= (dec_disp == DISP_LAZY);
      end
    end
  end

  // R10
  onehot_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones(rsp_outcome) == 1);

  // R10
  lvl_only_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_outcome[DISP_NOCP] |-> rsp_fault_lvl == '0);

  // R9
  end_block_lazy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_end_block || rsp_lazy_load) |-> rsp_outcome[DISP_LAZY]);

  // R11
  strobe_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R11
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(rsp_outcome) && $stable(rsp_fault_lvl) && !rsp_valid));

  // R7
  nonsecure_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && lazy_hit && !in_secure) |=> rsp_outcome[DISP_UNDEF]);

  // R3
  default_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !lazy_hit && !is_fp_cp) |=> (rsp_outcome[DISP_NOCP] && rsp_fault_lvl == $past(def_lvl)));

  // R1
  alias_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_cp == CP_W'(11)) |-> is_fp_cp);
endmodule

// File: tb/tb_cpd_resolver.sv
module tb_cpd_resolver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [3:0] req_cp = '0;
  logic       req_lazy = 1'b0, req_variant = 1'b0, req_load = 1'b0;
  logic       feat_v8 = 1'b0, feat_v81 = 1'b0, feat_fpu = 1'b0, feat_d32 = 1'b0;
  logic       in_secure = 1'b0;
  logic [1:0] fp_trap_lvl = '0, def_lvl = '0;
  logic       rsp_valid;
  logic [4:0] rsp_outcome;
  logic [1:0] rsp_fault_lvl;
  logic       rsp_lazy_load, rsp_end_block;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [4:0] exp_oc  = '0;
  logic [1:0] exp_lvl = '0;
  logic       exp_ld  = 1'b0, exp_eb = 1'b0, exp_rv = 1'b0;
  string      exp_tag = "R11";

  always #5 clk = ~clk;

  cpd_resolver dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cp(req_cp),
    .req_lazy(req_lazy), .req_variant(req_variant), .req_load(req_load),
    .feat_v8(feat_v8), .feat_v81(feat_v81), .feat_fpu(feat_fpu),
    .feat_d32(feat_d32), .in_secure(in_secure), .fp_trap_lvl(fp_trap_lvl),
    .def_lvl(def_lvl), .rsp_valid(rsp_valid), .rsp_outcome(rsp_outcome),
    .rsp_fault_lvl(rsp_fault_lvl), .rsp_lazy_load(rsp_lazy_load),
    .rsp_end_block(rsp_end_block)
  );

  // Behavioural reference: outcome index 0 pass,1 undef,2 nop,3 fault,4 lazy
  function automatic void model(input int cp, input bit lz, input bit vr, input bit ld,
                                input bit v8, input bit v81, input bit fpu, input bit d32,
                                input bit sec, input int trap, input int dl,
                                output int oc, output int lvl, output bit lload,
                                output bit endb, output string tag);
    int c;
    lvl = 0; lload = 0; endb = 0;
    if (lz && v8 && (!vr || v81)) begin
      if (!vr && d32)      begin oc = 1; tag = "R6"; end
      else if (!sec)       begin oc = 1; tag = "R7"; end
      else if (!fpu)       begin oc = 2; tag = "R8"; end
      else begin oc = 4; tag = "R9"; lload = ld; endb = 1; end
    end else begin
      c = cp;
      tag = "R4";
      if (c == 11) begin c = 10; tag = "R1"; end
      if (c == 8 || c == 9 || c == 14 || c == 15) begin
        tag = "R2";
        if (v81) c = 10;
      end
      if (c != 10) begin
        oc = 3; lvl = dl;
        if (tag != "R2") tag = "R3";
      end else if (trap != 0) begin
        oc = 3; lvl = trap;
      end else begin
        oc = 0;
      end
      if (lz) tag = "R5";
    end
  endfunction

  task automatic check_now();
    checks++;
    if (rsp_valid !== exp_rv || rsp_outcome !== exp_oc || rsp_fault_lvl !== exp_lvl ||
        rsp_lazy_load !== exp_ld || rsp_end_block !== exp_eb) begin
      fails++;
      $display("FAIL %s: got v=%b oc=%b lvl=%0d ld=%b eb=%b exp v=%b oc=%b lvl=%0d ld=%b eb=%b",
               exp_tag, rsp_valid, rsp_outcome, rsp_fault_lvl, rsp_lazy_load, rsp_end_block,
               exp_rv, exp_oc, exp_lvl, exp_ld, exp_eb);
    end
    if (exp_rv) begin
      checks++;
      if ($countones(rsp_outcome) != 1) begin
        fails++;
        $display("FAIL R10: outcome=%b expected exactly one bit (%b)", rsp_outcome, exp_oc);
      end
    end
  endtask

  task automatic apply(input bit vld, input int cp, input bit lz, input bit vr, input bit ld,
                       input bit v8, input bit v81, input bit fpu, input bit d32,
                       input bit sec, input int trap, input int dl);
    int oc, lvl;
    bit lload, endb;
    string tag;
    @(negedge clk);
    check_now();
    req_valid = vld; req_cp = 4'(cp); req_lazy = lz; req_variant = vr; req_load = ld;
    feat_v8 = v8; feat_v81 = v81; feat_fpu = fpu; feat_d32 = d32; in_secure = sec;
    fp_trap_lvl = 2'(trap); def_lvl = 2'(dl);
    exp_rv = vld;
    if (vld) begin
      model(cp, lz, vr, ld, v8, v81, fpu, d32, sec, trap, dl, oc, lvl, lload, endb, tag);
      exp_oc = 5'(1 << oc); exp_lvl = 2'(lvl); exp_ld = lload; exp_eb = endb; exp_tag = tag;
    end else begin
      exp_tag = "R11";
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_now(); // R11 reset state
    rst_n = 1'b1;
    // R1: cp 11 folds with and without v8.1
    apply(1, 11, 0, 0, 0, 1, 0, 1, 0, 1, 0, 1);
    apply(1, 11, 0, 0, 0, 1, 1, 1, 0, 1, 2, 1);
    // R2: extension aliases
    for (int c = 0; c < 16; c++) begin
      apply(1, c, 0, 0, 0, 1, 1, 1, 0, 1, 0, 2);
      apply(1, c, 0, 0, 0, 1, 0, 1, 0, 1, 0, 3);
    end
    // R3 / R4
    apply(1, 7, 0, 0, 0, 1, 1, 1, 0, 1, 3, 1);
    apply(1, 10, 0, 0, 0, 1, 1, 1, 0, 1, 3, 1);
    apply(1, 10, 0, 0, 0, 1, 1, 1, 0, 1, 0, 1);
    // R5: lazy not recognised
    apply(1, 10, 1, 0, 1, 0, 1, 1, 0, 1, 0, 1);
    apply(1, 10, 1, 1, 1, 1, 0, 1, 0, 1, 2, 1);
    apply(1, 3, 1, 1, 0, 1, 0, 1, 0, 0, 0, 2);
    // R6
    apply(1, 10, 1, 0, 1, 1, 1, 1, 1, 1, 0, 1);
    apply(1, 10, 1, 1, 1, 1, 1, 1, 1, 1, 0, 1);
    // R7: undef beats trap
    apply(1, 10, 1, 1, 0, 1, 1, 1, 0, 0, 2, 1);
    // R8
    apply(1, 10, 1, 0, 0, 1, 0, 0, 0, 1, 3, 1);
    // R9
    apply(1, 10, 1, 0, 1, 1, 1, 1, 0, 1, 2, 1);
    apply(1, 10, 1, 1, 0, 1, 1, 1, 0, 1, 0, 1);
    // R11: hold across idle cycles with changing inputs
    apply(0, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    apply(0, 10, 0, 0, 0, 1, 1, 1, 0, 1, 0, 0);
    for (int n = 0; n < 3000; n++) begin
      apply(($urandom % 4) != 0, $urandom % 16, $urandom % 2, $urandom % 2, $urandom % 2,
            $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
            $urandom % 4, $urandom % 4);
    end
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check_now();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R11: watchdog expired, got running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule